// File: doc/BRIEF.md
# Latency-Compensating Sample Window Capture

This block serves one channel of a sampling ADC. Each clock it takes one 10-bit sample and writes it into a circular delay line, so a trigger that arrives late still lines up with the signal it belongs to. The programmed latency sets how far back the captured samples reach. A latency of zero passes the current input straight through.

When a trigger is accepted, the block copies a window of consecutive delayed samples into one slot of a four-slot event queue. All events have the same length. A trigger that arrives while a window is still being written is held as pending. Its window begins on the very next cycle, so windows never overlap. A downstream processor picks an event by its offset from the oldest one and a sample by its index. It reads the data at once, and a release pulse returns the oldest slot to the queue. Triggers that cannot be served set a sticky overflow flag. The reader clears this flag when it releases an event.

Top module: `lat_capture`

## Requirements
- R1: Sample k of a captured event equals the `sampleIn` value present L clock edges before the k-th capture edge, where L is `latency` (0 to 511). With L = 0 the sample is the value present on that same edge. The first capture edge (k = 0) is the edge on which the window starts.
- R2: The window length is `winLen` when it is 1 to 128. A setting of 0 or of more than 128 gives 128. The length is taken when the window starts. An event that started on edge e is counted in `evtCount` after edge e + N - 1, where N is the length.
- R3: At most four events are stored. A trigger that would start a window while four events are held is dropped and sets `ovfFlag`.
- R4: A trigger that arrives while a window is being written is remembered. The next window starts on the edge after the current window's last sample.
- R5: Only one trigger is remembered per active window. Any further trigger during that window is dropped and sets `ovfFlag`.
- R6: `ovfFlag` stays set until a `rdRelease` pulse frees an event. If a new overflow occurs on the same edge, the flag stays set.
- R7: `rdData` shows, without a clock edge, sample `rdIdx` of the event at offset `rdSel` from the oldest stored event. Offset 0 is the oldest event.
- R8: A `rdRelease` pulse frees the oldest event and decrements `evtCount`. When the queue is empty, the pulse is ignored. `evtReady` is high exactly when `evtCount` is nonzero.
- R9: After reset, `evtCount` is 0, `evtReady` is 0 and `ovfFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 10 | ADC sample for this cycle |
| trigIn | input | 1 | Trigger, one cycle per trigger |
| latency | input | 9 | Delay in cycles, 0 to 511 |
| winLen | input | 8 | Samples per event; 0 or above 128 means 128 |
| rdSel | input | 2 | Event offset from the oldest stored event |
| rdIdx | input | 7 | Sample index within the selected event |
| rdRelease | input | 1 | Frees the oldest event |
| rdData | output | 10 | Selected sample |
| evtReady | output | 1 | At least one event stored |
| evtCount | output | 3 | Number of stored events |
| ovfFlag | output | 1 | Sticky overflow indication |

## Verification
The input is a ramp that rises by one each cycle. Every captured sample therefore identifies the exact cycle it came from, and the bench can tell the latency error apart from an off-by-one window start. An isolated trigger is tried at latencies 0, 1, 2 and 511. A trigger that lands inside an open window checks that the pending window starts exactly one edge after the current one ends, and a third trigger in that window must set the overflow flag. Filling all four slots and then triggering once more separates the full-queue drop from the pending-trigger drop. An oversize length setting is checked for clamping by the cycle on which the event appears.

// File: rtl/lat_capture_pkg.sv
package lat_capture_pkg;
  localparam int SAMPLE_W  = 10;
  localparam int DLY_DEPTH = 512;
  localparam int MAX_WIN   = 128;
  localparam int NUM_EVT   = 4;

  localparam int LAT_W  = $clog2(DLY_DEPTH);
  localparam int IDX_W  = $clog2(MAX_WIN);
  localparam int LEN_W  = IDX_W + 1;
  localparam int SLOT_W = $clog2(NUM_EVT);
  localparam int CNT_W  = $clog2(NUM_EVT + 1);

  // Write strobes from control to the event store
  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [IDX_W-1:0]  wrIdx;
  } capStrobe_t;
endpackage

// File: rtl/lat_capture_dp.sv
module lat_capture_dp
  import lat_capture_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int DEPTH = DLY_DEPTH,
  parameter int WIN   = MAX_WIN,
  parameter int EVT   = NUM_EVT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W-1:0]         sampleIn,
  input  logic [LAT_W-1:0]     latency,
  input  capStrobe_t           strobe,
  input  logic [SLOT_W-1:0]    rdSlot,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [W-1:0]         rdData
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = SLOT_W + IDX_W;

  logic [W-1:0]  dlyMem [DEPTH];
  logic [W-1:0]  evtMem [EVT*WIN];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] tapAddr;
  logic [W-1:0]  delayed;
  logic [EW-1:0] evtWrAddr;
  logic [EW-1:0] evtRdAddr;

  // Delay line: write pointer runs freely, the tap trails it by latency
  always_ff @(posedge clk) begin
    if (!rstN) wrPtr <= '0;
    else       wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    dlyMem[wrPtr] <= sampleIn;
  end

  always_comb begin
    tapAddr = wrPtr - AW'(latency);
    delayed = (latency == '0) ? sampleIn : dlyMem[tapAddr];
  end

  // Event store, slot-major layout
  assign evtWrAddr = {strobe.wrSlot, strobe.wrIdx};
  assign evtRdAddr = {rdSlot, rdIdx};

  always_ff @(posedge clk) begin
    if (strobe.wrEn) evtMem[evtWrAddr] <= delayed;
  end

  assign rdData = evtMem[evtRdAddr];
endmodule

// File: rtl/lat_capture_ctrl.sv
module lat_capture_ctrl
  import lat_capture_pkg::*;
#(
  parameter int WIN = MAX_WIN,
  parameter int EVT = NUM_EVT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [LEN_W-1:0]  winLen,
  input  logic [SLOT_W-1:0] rdSel,
  input  logic              rdRelease,
  output capStrobe_t        strobe,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [CNT_W-1:0]  evtCount,
  output logic              ovfFlag
);
  logic              active;
  logic              pending;
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  curLen;
  logic [SLOT_W-1:0] wrSlot;
  logic [SLOT_W-1:0] rdPtr;

  logic [LEN_W-1:0]  effLen;
  logic hasRoom, wantStart, doStart, lastWr, oneShot, commit, relEff, ovfSet;

  always_comb begin
    effLen    = (winLen == '0 || winLen > LEN_W'(WIN)) ? LEN_W'(WIN) : winLen;
    hasRoom   = evtCount < CNT_W'(EVT);
    wantStart = !active && (pending || trigIn);
    doStart   = wantStart && hasRoom;
    lastWr    = active && (idx == curLen - 1'b1);
    oneShot   = doStart && (effLen == LEN_W'(1));
    commit    = lastWr || oneShot;
    relEff    = rdRelease && (evtCount != '0);
    ovfSet    = (wantStart && !hasRoom) || (active && trigIn && pending);

    strobe.wrEn   = doStart || active;
    strobe.wrSlot = wrSlot;
    strobe.wrIdx  = doStart ? '0 : idx[IDX_W-1:0];
  end

  assign rdSlot = rdPtr + rdSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      pending  <= 1'b0;
      idx      <= '0;
      curLen   <= LEN_W'(WIN);
      wrSlot   <= '0;
      rdPtr    <= '0;
      evtCount <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      // Window sequencing
      if (doStart) begin
        active <= !oneShot;
        idx    <= LEN_W'(1);
        curLen <= effLen;
      end else if (lastWr) begin
        active <= 1'b0;
        idx    <= '0;
      end else if (active) begin
        idx <= idx + 1'b1;
      end

      // Single pending trigger
      if (!active)     pending <= doStart && pending && trigIn;
      else if (trigIn) pending <= 1'b1;

      // Queue bookkeeping
      if (commit) wrSlot <= wrSlot + 1'b1;
      if (relEff) rdPtr  <= rdPtr + 1'b1;
      evtCount <= evtCount + CNT_W'(commit) - CNT_W'(relEff);

      // Sticky overflow, set wins over clear
      if (ovfSet)      ovfFlag <= 1'b1;
      else if (relEff) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/lat_capture.sv
module lat_capture
  import lat_capture_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                trigIn,
  input  logic [LAT_W-1:0]    latency,
  input  logic [LEN_W-1:0]    winLen,
  input  logic [SLOT_W-1:0]   rdSel,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic                rdRelease,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                evtReady,
  output logic [CNT_W-1:0]    evtCount,
  output logic                ovfFlag
);
  capStrobe_t        strobe;
  logic [SLOT_W-1:0] rdSlot;

  lat_capture_ctrl #(.WIN(MAX_WIN), .EVT(NUM_EVT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .winLen    (winLen),
    .rdSel     (rdSel),
    .rdRelease (rdRelease),
    .strobe    (strobe),
    .rdSlot    (rdSlot),
    .evtCount  (evtCount),
    .ovfFlag   (ovfFlag)
  );

  lat_capture_dp #(.W(SAMPLE_W), .DEPTH(DLY_DEPTH), .WIN(MAX_WIN), .EVT(NUM_EVT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .latency  (latency),
    .strobe   (strobe),
    .rdSlot   (rdSlot),
    .rdIdx    (rdIdx),
    .rdData   (rdData)
  );

  assign evtReady = (evtCount != '0);
endmodule

// File: rtl/lat_capture_chk.sv
module lat_capture_chk
  import lat_capture_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             rdRelease,
  input logic [CNT_W-1:0] evtCount,
  input logic             ovfFlag,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    evtCount <= CNT_W'(NUM_EVT)); // R3

  AST_WRITE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> evtCount < CNT_W'(NUM_EVT)); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != '0) |-> ($past(wrEn) && wrIdx == $past(wrIdx) + 1'b1)); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !rdRelease) |=> ovfFlag); // R6

  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (rdRelease && evtCount == '0) |=> evtCount <= CNT_W'(1)); // R8
endmodule

bind lat_capture lat_capture_chk chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdRelease (rdRelease),
  .evtCount  (evtCount),
  .ovfFlag   (ovfFlag),
  .wrEn      (strobe.wrEn),
  .wrIdx     (strobe.wrIdx)
);

// File: tb/lat_capture_test.sv
module lat_capture_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] sampleIn = '0;
  logic       trigIn;
  logic [8:0] latency;
  logic [7:0] winLen;
  logic [1:0] rdSel;
  logic [6:0] rdIdx;
  logic       rdRelease;
  logic [9:0] rdData;
  logic       evtReady;
  logic [2:0] evtCount;
  logic       ovfFlag;

  int nRun  = 0;
  int nFail = 0;

  always #10 clk = ~clk;
  always @(negedge clk) sampleIn <= sampleIn + 1'b1;

  lat_capture uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .trigIn(trigIn),
    .latency(latency), .winLen(winLen), .rdSel(rdSel), .rdIdx(rdIdx),
    .rdRelease(rdRelease), .rdData(rdData), .evtReady(evtReady),
    .evtCount(evtCount), .ovfFlag(ovfFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Trigger for the next edge, returns the sampleIn value seen at that edge
  task automatic fire(output logic [9:0] v);
    @(negedge clk);
    trigIn = 1'b1;
    #1 v = sampleIn;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic pulseRelease();
    @(negedge clk);
    rdRelease = 1'b1;
    @(negedge clk);
    rdRelease = 1'b0;
  endtask

  task automatic checkEvent(input logic [1:0] sel, input int len,
                            input logic [9:0] base, input string req);
    bit ok = 1'b1;
    int badAct = 0, badExp = 0;
    for (int k = 0; k < len; k++) begin
      logic [9:0] e;
      e = base + 10'(k);
      rdSel = sel;
      rdIdx = 7'(k);
      #1;
      if (ok && rdData !== e) begin
        ok = 1'b0; badAct = int'(rdData); badExp = int'(e);
      end
    end
    check(ok, req, badAct, badExp);
  endtask

  task automatic testReset();
    check(evtCount == 0, "R9 count", evtCount, 0);
    check(evtReady == 0, "R9 ready", evtReady, 0);
    check(ovfFlag == 0, "R9 ovf", ovfFlag, 0);
  endtask

  task automatic testSingle();
    logic [9:0] v;
    latency = 9'd1; winLen = 8'd8;
    fire(v);
    waitNeg(10);
    check(evtCount == 1, "R8 count one", evtCount, 1);
    check(evtReady == 1, "R8 ready", evtReady, 1);
    checkEvent(2'd0, 8, v - 10'd1, "R1 R7 latency one");
    pulseRelease();
    check(evtCount == 0, "R8 release", evtCount, 0);
  endtask

  task automatic testPassThrough();
    logic [9:0] v;
    latency = 9'd0; winLen = 8'd5;
    fire(v);
    waitNeg(8);
    checkEvent(2'd0, 5, v, "R1 zero latency");
    pulseRelease();
  endtask

  task automatic testPending();
    logic [9:0] va, vb, vc;
    latency = 9'd1; winLen = 8'd8;
    fire(va);            // edge e
    fire(vb);            // edge e+2, pending
    check(ovfFlag == 0, "R4 no ovf on first pending", ovfFlag, 0);
    fire(vc);            // edge e+4, second extra trigger
    check(ovfFlag == 1, "R5 extra trigger ovf", ovfFlag, 1);
    waitNeg(20);
    check(evtCount == 2, "R5 two events", evtCount, 2);
    checkEvent(2'd0, 8, va - 10'd1, "R1 first window");
    checkEvent(2'd1, 8, va + 10'd7, "R4 back to back window");
    pulseRelease();
    check(ovfFlag == 0, "R6 ovf cleared by release", ovfFlag, 0);
    checkEvent(2'd0, 8, va + 10'd7, "R7 oldest after release");
    pulseRelease();
    pulseRelease();      // empty queue
    check(evtCount == 0, "R8 release on empty ignored", evtCount, 0);
    check(evtReady == 0, "R8 ready low", evtReady, 0);
  endtask

  task automatic testFull();
    logic [9:0] v [4];
    logic [9:0] vx;
    latency = 9'd2; winLen = 8'd4;
    for (int i = 0; i < 4; i++) begin
      fire(v[i]);
      waitNeg(6);
    end
    check(evtCount == 4, "R3 four stored", evtCount, 4);
    check(ovfFlag == 0, "R3 no ovf yet", ovfFlag, 0);
    fire(vx);
    waitNeg(6);
    check(ovfFlag == 1, "R3 full ovf", ovfFlag, 1);
    check(evtCount == 4, "R3 count held", evtCount, 4);
    checkEvent(2'd3, 4, v[3] - 10'd2, "R3 R7 newest intact");
    waitNeg(3);
    check(ovfFlag == 1, "R6 ovf sticky", ovfFlag, 1);
    for (int i = 0; i < 4; i++) pulseRelease();
    check(evtCount == 0, "R8 drained", evtCount, 0);
    check(ovfFlag == 0, "R6 cleared", ovfFlag, 0);
  endtask

  task automatic testLongWindow();
    logic [9:0] v;
    latency = 9'd511; winLen = 8'd200;
    waitNeg(600);
    fire(v);
    waitNeg(126);
    check(evtCount == 0, "R2 not yet committed", evtCount, 0);
    waitNeg(1);
    check(evtCount == 1, "R2 committed at length 128", evtCount, 1);
    checkEvent(2'd0, 128, v - 10'd511, "R1 R2 max latency window");
    pulseRelease();
  endtask

  initial begin
    rstN = 1'b0; trigIn = 1'b0; latency = 9'd1; winLen = 8'd0;
    rdSel = '0; rdIdx = '0; rdRelease = 1'b0;
    waitNeg(4);
    rstN = 1'b1;
    waitNeg(2);
    testReset();
    testSingle();
    testPassThrough();
    testPending();
    testFull();
    testLongWindow();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #4000000;
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule